// File: doc/BRIEF.md
# ADC Conversion Flag and Interrupt Controller

This block keeps the per-slot conversion-complete flags and the sequence-complete flag for a multi-slot analog-to-digital sequencer. It also drives the two interrupt request lines that software watches. The sequencer reports each finished conversion as a one-cycle completion event. The event carries the slot number, the result of the automatic compare for that slot, and a marker for the last conversion of a sequence. The register front end passes in strobes for writes to the flag register and for reads and writes of each result register. The block uses these strobes to clear flags.

Flags can be cleared in one of two ways. In normal mode, software writes a 1 to the flag bit. In fast-clear mode, the flag clears as a side effect of touching the result register: a read clears it for slots without compare, and a write clears it for slots with compare. A conversion that finishes while the device is moving between run and stop mode is thrown away completely. It sets no flag, causes no result store and counts for no compare. For every conversion it accepts, the block issues a store strobe one cycle later for the external result storage.

Top module: `adc_flag_irq`

## Requirements
- R1: After a synchronous reset, all conversion flags, the sequence flag, both interrupt lines and the store strobe are 0.
- R2: An accepted completion for slot n whose compare-enable bit is 0 sets flag n on the next clock edge. Other flags are left unchanged.
- R3: An accepted completion for slot n whose compare-enable bit is 1 sets flag n only if its compare-hit input is 1. Otherwise flag n is left unchanged.
- R4: When fast clear is 0, a flag-register write clears exactly the flags whose write-data bit is 1. Result-register reads and writes clear nothing.
- R5: When fast clear is 1 and slot n has compare disabled, a read of result register n clears flag n. A write to it does not.
- R6: When fast clear is 1 and slot n has compare enabled, a write to result register n clears flag n. A read of it does not.
- R7: When fast clear is 1, writes to the flag register have no effect on the flags.
- R8: If a set and a clear reach the same flag in the same cycle, the flag ends up set.
- R9: An accepted completion marked last sets the sequence flag, whatever its compare outcome. A sequence-clear strobe clears the flag, unless a set arrives in the same cycle.
- R10: The sequence interrupt is 1 exactly while its enable is 1 and the sequence flag is 1. It follows a change of the enable in the same cycle.
- R11: The compare interrupt is 1 exactly while its enable is 1 and at least one flag is set whose compare-enable bit is 1.
- R12: A completion that arrives while the mode-transition input is 1 changes no flag and no sequence flag, and produces no store strobe.
- R13: An accepted completion for slot n produces a one-cycle store strobe on the next cycle, with the store index equal to n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle conversion completion event |
| conv_slot | input | SLOT_W | Slot number of the completing conversion |
| conv_hit | input | 1 | Automatic compare succeeded for this conversion |
| conv_last | input | 1 | Completion is the last of the sequence |
| mode_trans | input | 1 | Run/stop mode transition in progress |
| flag_wr | input | 1 | Write strobe for the flag register |
| flag_wdata | input | N_SLOTS | Write data; a 1 bit requests a clear |
| seq_clr | input | 1 | Write-1 strobe clearing the sequence flag |
| res_rd | input | 1 | Result register read strobe |
| res_wr | input | 1 | Result register write strobe |
| res_idx | input | SLOT_W | Result register addressed by the strobes |
| cmp_en_mask | input | N_SLOTS | Per-slot compare enable |
| fast_clr | input | 1 | Selects fast-clear mode |
| seq_irq_en | input | 1 | Sequence interrupt enable |
| cmp_irq_en | input | 1 | Compare interrupt enable |
| conv_flags | output | N_SLOTS | Registered conversion-complete flags |
| seq_flag | output | 1 | Registered sequence-complete flag |
| seq_irq | output | 1 | Sequence interrupt request (level) |
| cmp_irq | output | 1 | Compare interrupt request (level) |
| res_store_en | output | 1 | Registered store strobe for result storage |
| res_store_idx | output | SLOT_W | Slot to be stored |

## Verification
The assertions check the following on every cycle. A pending set always wins on the next edge. Flags stay put when no set or clear is pending. Normal mode never turns a result access into a clear. Fast clear never clears more than one slot at a time. A transition-window completion never sets anything or produces a store. Either interrupt line, when high, is backed by an enabled, set source. Only the bench's scenarios can show the mode-dependent choice between read-clear and write-clear for each slot. They also show that flag-register writes are ignored in fast-clear mode, that a failed compare still completes a sequence, and the exact flag values after mixed sequences of sets and clears.

// File: rtl/adc_flag_pkg.sv
package adc_flag_pkg;
  // Qualified conversion event after transition filtering
  typedef struct packed {
    logic accept;
    logic set_flag;
    logic last;
  } conv_evt_t;
endpackage

// File: rtl/adc_flag_decode.sv
module adc_flag_decode
  import adc_flag_pkg::*;
#(
  parameter int N_SLOTS = 8,
  localparam int SLOT_W = $clog2(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               conv_done,
  input  logic [SLOT_W-1:0]  conv_slot,
  input  logic               conv_hit,
  input  logic               conv_last,
  input  logic               mode_trans,
  input  logic               flag_wr,
  input  logic [N_SLOTS-1:0] flag_wdata,
  input  logic               res_rd,
  input  logic               res_wr,
  input  logic [SLOT_W-1:0]  res_idx,
  input  logic [N_SLOTS-1:0] cmp_en_mask,
  input  logic               fast_clr,
  output conv_evt_t          evt,
  output logic [N_SLOTS-1:0] set_vec,
  output logic [N_SLOTS-1:0] clr_vec
);
  always_comb begin
    evt.accept   = conv_done && !mode_trans;
    evt.set_flag = evt.accept && (!cmp_en_mask[conv_slot] || conv_hit);
    evt.last     = evt.accept && conv_last;
  end

  for (genvar n = 0; n < N_SLOTS; n++) begin : g_slot
    logic hit_slot, hit_res, fast_term;
    assign hit_slot   = (conv_slot == SLOT_W'(n));
    assign hit_res    = (res_idx == SLOT_W'(n));
    assign fast_term  = hit_res && (cmp_en_mask[n] ? res_wr : res_rd);
    assign set_vec[n] = evt.set_flag && hit_slot;
    assign clr_vec[n] = fast_clr ? fast_term : (flag_wr && flag_wdata[n]);
  end

  // R4: normal mode never clears through result access
  p_no_res_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (!fast_clr && !flag_wr) |-> (clr_vec == '0));
  // R5/R6: fast clear touches at most one slot
  p_fast_single_r5: assert property (@(posedge clk) disable iff (rst)
    fast_clr |-> $onehot0(clr_vec));
  // R12: transition window blocks every set
  p_trans_block_r12: assert property (@(posedge clk) disable iff (rst)
    mode_trans |-> (set_vec == '0 && !evt.last));
endmodule

// File: rtl/adc_flag_regs.sv
module adc_flag_regs #(
  parameter int N_SLOTS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_SLOTS-1:0] set_vec,
  input  logic [N_SLOTS-1:0] clr_vec,
  output logic [N_SLOTS-1:0] flags
);
  for (genvar n = 0; n < N_SLOTS; n++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             flags[n] <= 1'b0;
      else if (set_vec[n]) flags[n] <= 1'b1;
      else if (clr_vec[n]) flags[n] <= 1'b0;
    end

    // R8: a set always lands, even against a clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
      set_vec[n] |=> flags[n]);
    // R2: no event leaves the bit alone
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (!set_vec[n] && !clr_vec[n]) |=> $stable(flags[n]));
  end
endmodule

// File: rtl/adc_irq_gen.sv
module adc_irq_gen #(
  parameter int N_SLOTS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_SLOTS-1:0] flags,
  input  logic [N_SLOTS-1:0] cmp_en_mask,
  input  logic               seq_flag,
  input  logic               seq_irq_en,
  input  logic               cmp_irq_en,
  output logic               seq_irq,
  output logic               cmp_irq
);
  logic any_cmp;
  assign any_cmp = |(flags & cmp_en_mask);
  assign seq_irq = seq_irq_en && seq_flag;
  assign cmp_irq = cmp_irq_en && any_cmp;

  // R11: compare request needs a set compare-enabled flag
  p_cmp_src_r11: assert property (@(posedge clk) disable iff (rst)
    cmp_irq |-> (cmp_irq_en && ($countones(flags & cmp_en_mask) > 0)));
  // R10: sequence request needs the sequence flag
  p_seq_src_r10: assert property (@(posedge clk) disable iff (rst)
    seq_irq |-> seq_flag);
endmodule

// File: rtl/adc_flag_irq.sv
module adc_flag_irq
  import adc_flag_pkg::*;
#(
  parameter int N_SLOTS = 8,
  localparam int SLOT_W = $clog2(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               conv_done,
  input  logic [SLOT_W-1:0]  conv_slot,
  input  logic               conv_hit,
  input  logic               conv_last,
  input  logic               mode_trans,
  input  logic               flag_wr,
  input  logic [N_SLOTS-1:0] flag_wdata,
  input  logic               seq_clr,
  input  logic               res_rd,
  input  logic               res_wr,
  input  logic [SLOT_W-1:0]  res_idx,
  input  logic [N_SLOTS-1:0] cmp_en_mask,
  input  logic               fast_clr,
  input  logic               seq_irq_en,
  input  logic               cmp_irq_en,
  output logic [N_SLOTS-1:0] conv_flags,
  output logic               seq_flag,
  output logic               seq_irq,
  output logic               cmp_irq,
  output logic               res_store_en,
  output logic [SLOT_W-1:0]  res_store_idx
);
  conv_evt_t          evt;
  logic [N_SLOTS-1:0] set_vec, clr_vec;

  adc_flag_decode #(.N_SLOTS(N_SLOTS)) u_dec (
    .clk(clk), .rst(rst),
    .conv_done(conv_done), .conv_slot(conv_slot), .conv_hit(conv_hit),
    .conv_last(conv_last), .mode_trans(mode_trans),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .res_rd(res_rd), .res_wr(res_wr), .res_idx(res_idx),
    .cmp_en_mask(cmp_en_mask), .fast_clr(fast_clr),
    .evt(evt), .set_vec(set_vec), .clr_vec(clr_vec)
  );

  adc_flag_regs #(.N_SLOTS(N_SLOTS)) u_regs (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec),
    .flags(conv_flags)
  );

  always_ff @(posedge clk) begin
    if (rst)           seq_flag <= 1'b0;
    else if (evt.last) seq_flag <= 1'b1;
    else if (seq_clr)  seq_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_store_en  <= 1'b0;
      res_store_idx <= '0;
    end else begin
      res_store_en  <= evt.accept;
      if (evt.accept) res_store_idx <= conv_slot;
    end
  end

  adc_irq_gen #(.N_SLOTS(N_SLOTS)) u_irq (
    .clk(clk), .rst(rst), .flags(conv_flags), .cmp_en_mask(cmp_en_mask),
    .seq_flag(seq_flag), .seq_irq_en(seq_irq_en), .cmp_irq_en(cmp_irq_en),
    .seq_irq(seq_irq), .cmp_irq(cmp_irq)
  );

  // R13: accepted completion is followed by a store strobe for its slot
  p_store_follow_r13: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !mode_trans) |=> (res_store_en && res_store_idx == $past(conv_slot)));
  // R12: no store strobe for a transition-window completion
  p_trans_nostore_r12: assert property (@(posedge clk) disable iff (rst)
    (conv_done && mode_trans) |=> !res_store_en);
  // R9: last completion raises the sequence flag
  p_seq_set_r9: assert property (@(posedge clk) disable iff (rst)
    (conv_done && conv_last && !mode_trans) |=> seq_flag);
endmodule

// File: tb/sim_adc_flag_irq.sv
module sim_adc_flag_irq;
  localparam int N = 8;
  localparam int SW = 3;

  logic clk = 0, rst = 1;
  logic conv_done = 0, conv_hit = 0, conv_last = 0, mode_trans = 0;
  logic [SW-1:0] conv_slot = '0, res_idx = '0;
  logic flag_wr = 0, seq_clr = 0, res_rd = 0, res_wr = 0;
  logic [N-1:0] flag_wdata = '0, cmp_en_mask = 8'hF0;
  logic fast_clr = 0, seq_irq_en = 0, cmp_irq_en = 0;
  logic [N-1:0] conv_flags;
  logic seq_flag, seq_irq, cmp_irq, res_store_en;
  logic [SW-1:0] res_store_idx;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  adc_flag_irq #(.N_SLOTS(N)) u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    conv_done = 0; flag_wr = 0; seq_clr = 0; res_rd = 0; res_wr = 0;
    conv_hit = 0; conv_last = 0;
  endtask

  task automatic conv(int s, bit h, bit l);
    conv_done = 1; conv_slot = SW'(s); conv_hit = h; conv_last = l;
    tick();
  endtask

  // {fast_clr, op, idx, arg, expected flags}; op 0 conv(arg0 hit),1 flag wr,2 res rd,3 res wr
  localparam logic [22:0] VEC [15] = '{
    {1'b0, 3'd0, 3'd0, 8'h00, 8'h01},  // R2
    {1'b0, 3'd0, 3'd1, 8'h00, 8'h03},  // R2
    {1'b0, 3'd0, 3'd4, 8'h00, 8'h03},  // R3 miss
    {1'b0, 3'd0, 3'd4, 8'h01, 8'h13},  // R3 hit
    {1'b0, 3'd0, 3'd5, 8'h01, 8'h33},  // R3 hit
    {1'b0, 3'd2, 3'd0, 8'h00, 8'h33},  // R4 read ignored
    {1'b0, 3'd1, 3'd0, 8'h01, 8'h32},  // R4
    {1'b0, 3'd1, 3'd0, 8'h20, 8'h12},  // R4
    {1'b1, 3'd2, 3'd1, 8'h00, 8'h10},  // R5
    {1'b1, 3'd0, 3'd2, 8'h00, 8'h14},  // R2
    {1'b1, 3'd3, 3'd2, 8'h00, 8'h14},  // R5 write ignored
    {1'b1, 3'd2, 3'd4, 8'h00, 8'h14},  // R6 read ignored
    {1'b1, 3'd3, 3'd4, 8'h00, 8'h04},  // R6
    {1'b1, 3'd1, 3'd0, 8'hFF, 8'h04},  // R7
    {1'b1, 3'd2, 3'd2, 8'h00, 8'h00}   // R5
  };

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(posedge clk); @(posedge clk); #1;
    rst = 0;
    // R1 reset state
    check("R1 flags", conv_flags, 0);
    check("R1 seq", {seq_flag, seq_irq, cmp_irq, res_store_en}, 0);

    for (int i = 0; i < 15; i++) begin
      logic [22:0] e;
      e = VEC[i];
      fast_clr = e[22];
      case (e[21:19])
        3'd0: conv(int'(e[18:16]), e[8], 1'b0);
        3'd1: begin flag_wr = 1; flag_wdata = e[15:8]; tick(); end
        3'd2: begin res_rd = 1; res_idx = e[18:16]; tick(); end
        default: begin res_wr = 1; res_idx = e[18:16]; tick(); end
      endcase
      check($sformatf("R2-7 vector %0d", i), conv_flags, e[7:0]);
    end

    // R11 compare interrupt
    fast_clr = 0; cmp_irq_en = 1;
    conv(0, 0, 0);
    check("R11 no cmp source", cmp_irq, 0);
    conv(6, 1, 0);
    check("R11 flags", conv_flags, 8'h41);
    check("R11 cmp irq on", cmp_irq, 1);
    cmp_irq_en = 0; #1;
    check("R11 enable off", cmp_irq, 0);
    flag_wr = 1; flag_wdata = 8'h41; tick();
    check("R4 clear both", conv_flags, 0);

    // R9 / R10 sequence flag and interrupt
    conv(3, 0, 1);
    check("R9 seq set", seq_flag, 1);
    check("R10 irq gated", seq_irq, 0);
    seq_irq_en = 1; #1;
    check("R10 irq on", seq_irq, 1);
    seq_clr = 1; tick();
    check("R9 seq clr", {seq_flag, seq_irq}, 0);
    conv(7, 0, 1);
    check("R9 seq on compare miss", seq_flag, 1);
    check("R3 miss flag", conv_flags, 8'h08);
    conv_done = 1; conv_slot = 3'd1; conv_last = 1; seq_clr = 1; tick();
    check("R9 set beats clear", seq_flag, 1);
    seq_clr = 1; tick();
    flag_wr = 1; flag_wdata = 8'h0A; tick();
    check("R4 cleanup", conv_flags, 0);

    // R8 set vs clear same cycle
    conv_done = 1; conv_slot = 3'd2; flag_wr = 1; flag_wdata = 8'h04; tick();
    check("R8 normal mode", conv_flags, 8'h04);
    fast_clr = 1;
    conv_done = 1; conv_slot = 3'd2; res_rd = 1; res_idx = 3'd2; tick();
    check("R8 fast mode", conv_flags, 8'h04);
    res_rd = 1; res_idx = 3'd2; tick();
    check("R5 cleanup", conv_flags, 0);

    // R12 transition window
    mode_trans = 1;
    conv(5, 1, 1);
    check("R12 flags", conv_flags, 0);
    check("R12 seq", seq_flag, 0);
    check("R12 store", res_store_en, 0);
    mode_trans = 0;

    // R13 store strobe
    conv(3, 0, 0);
    check("R13 strobe", res_store_en, 1);
    check("R13 idx", res_store_idx, 3);
    tick();
    check("R13 one cycle", res_store_en, 0);

    // R1 reset mid-run
    rst = 1; tick(); rst = 0;
    check("R1 mid reset", {conv_flags, seq_flag, res_store_en}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule